// File: doc/BRIEF.md
# Stereo Limiter Gain Controller

This block is the attenuating half of an automatic level control loop on a stereo digital audio path. On every sample strobe it measures the magnitude of the left and right samples, taken after the gain stage but before saturation. It compares the louder of the two against a selectable limiter threshold and against three overload marks: digital full scale, full scale +6 dB and full scale +12 dB. When the threshold is reached, it lowers one shared 8-bit gain code that feeds both channels. The size of the cut depends on the step select input and on how far the level is over.

A cut can be applied at once or deferred. With zero-cross detection on and the level below full scale, the cut waits for each channel's own zero crossing, or for a timeout counted in sample periods, so that it does not click. An overload above full scale, or zero-cross detection being off, forces an immediate cut. Raising the gain again, the multiplier and the mapping from code to linear gain belong to other blocks.

Top module: `alc_limiter_top`

## Requirements
- R1: While `lim_en` is 0, both gain codes and any pending change stay frozen whatever the samples are.
- R2: The threshold is crossed when |sample| >= a linear magnitude chosen by `thr_sel`: 0 -> 24573, 1 -> 20438, 2 -> 16423, 3 -> 12315. Below it on both channels, no new cut starts.
- R3: The overload region is that of the louder channel: full scale at |x| >= 32768, +6 dB at |x| >= 65536, +12 dB at |x| >= 131072.
- R4: The cut size in codes, for threshold/FS/+6/+12 regions, is: `stp_sel` 0 -> 1,1,1,1; 1 -> 2,2,2,2; 2 -> 2,4,4,8; 3 -> 1,2,4,8.
- R5: With zero-cross detection on and a region at or above full scale, both codes drop by the R4 step on that strobe, counted from the pending target if one exists. Any pending change is dropped.
- R6: With `zc_off` = 1, a level over the threshold cuts both codes by exactly 1 on that strobe, whatever `stp_sel` is. A pending change is applied at once on the next strobe.
- R7: A change that crosses only the threshold becomes pending (target = code minus step). It is applied to each channel on a later strobe where that channel crosses zero: a sign change from its previous sample, or a sample of 0.
- R8: A pending change is forced onto both channels on the 2^(7+`tmo_sel`)-th strobe after it was created (128, 256, 512 or 1024).
- R9: Cuts repeat on later strobes while the level stays over the threshold. A new pending change is created only when none is outstanding.
- R10: Gain codes are 8 bits, reset to 145, never rise, saturate at 0, and are equal whenever no change is pending.
- R11: Gain codes change only on a clock edge where `smp_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle sample strobe |
| smp_l | input | 18 | Left pre-saturation sample, signed |
| smp_r | input | 18 | Right pre-saturation sample, signed |
| lim_en | input | 1 | Limiter enable |
| thr_sel | input | 2 | Threshold select |
| stp_sel | input | 2 | Step size select |
| zc_off | input | 1 | 1 disables zero-cross waiting |
| tmo_sel | input | 2 | Zero-cross timeout select |
| gain_l | output | 8 | Left gain code |
| gain_r | output | 8 | Right gain code |

## Verification
The main function is tried with four patterns. A steady tone above the threshold without sign changes shows that the timeout alone resolves a pending cut. Opposite-signed crossings on the two channels show that a deferred cut lands per channel and that the codes realign. Ever larger overloads under each step select separate the four regions of the step table. Zero-cross-disabled runs sweep each threshold at one below and exactly at its magnitude, then drive the code to 0. A disabled interval with a full overload shows that nothing moves.

// File: rtl/alc_pkg.sv
package alc_pkg;
  typedef enum logic [2:0] {
    LV_NONE = 3'd0,
    LV_THR  = 3'd1,
    LV_FS   = 3'd2,
    LV_P6   = 3'd3,
    LV_P12  = 3'd4
  } lvl_t;

  function automatic logic [16:0] thr_mag(input logic [1:0] sel);
    case (sel)
      2'd0:    thr_mag = 17'd24573;
      2'd1:    thr_mag = 17'd20438;
      2'd2:    thr_mag = 17'd16423;
      default: thr_mag = 17'd12315;
    endcase
  endfunction
endpackage

// File: rtl/alc_lvl_det.sv
module alc_lvl_det #(
  parameter int DW = 18,
  parameter int SW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [DW-1:0] smp,
  input  logic [1:0]           thr_sel,
  output alc_pkg::lvl_t        lvl,
  output logic                 zc
);
  localparam logic [DW-1:0] FS_MAG  = DW'(1) << (SW - 1);
  localparam logic [DW-1:0] P6_MAG  = FS_MAG << 1;
  localparam logic [DW-1:0] P12_MAG = FS_MAG << 2;

  logic [DW-1:0] mag;
  logic [DW-1:0] thr;
  logic          prev_neg_q, prev_neg_d;

  assign mag = smp[DW-1] ? (~smp + 1'b1) : smp;
  assign thr = DW'(alc_pkg::thr_mag(thr_sel));

  always_comb begin
    if (mag >= P12_MAG)     lvl = alc_pkg::LV_P12;
    else if (mag >= P6_MAG) lvl = alc_pkg::LV_P6;
    else if (mag >= FS_MAG) lvl = alc_pkg::LV_FS;
    else if (mag >= thr)    lvl = alc_pkg::LV_THR;
    else                    lvl = alc_pkg::LV_NONE;
  end

  assign zc         = (smp == '0) || (smp[DW-1] != prev_neg_q);
  assign prev_neg_d = vld ? smp[DW-1] : prev_neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_neg_q <= 1'b0;
    else        prev_neg_q <= prev_neg_d;
  end
endmodule

// File: rtl/alc_step_lut.sv
module alc_step_lut (
  input  logic [1:0]    stp_sel,
  input  logic          zc_off,
  input  alc_pkg::lvl_t lvl,
  output logic [3:0]    step
);
  always_comb begin
    step = 4'd1;
    if (!zc_off) begin
      case (stp_sel)
        2'd0: step = 4'd1;
        2'd1: step = 4'd2;
        2'd2: case (lvl)
                alc_pkg::LV_FS, alc_pkg::LV_P6: step = 4'd4;
                alc_pkg::LV_P12:                step = 4'd8;
                default:                        step = 4'd2;
              endcase
        default: case (lvl)
                alc_pkg::LV_FS:  step = 4'd2;
                alc_pkg::LV_P6:  step = 4'd4;
                alc_pkg::LV_P12: step = 4'd8;
                default:         step = 4'd1;
              endcase
      endcase
    end
  end
endmodule

// File: rtl/alc_gain_ctl.sv
module alc_gain_ctl #(
  parameter int          GW       = 8,
  parameter logic [GW-1:0] GAIN_RST = 8'd145,
  parameter int          TMO_LOG  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          en,
  input  logic          zc_off,
  input  logic [1:0]    tmo_sel,
  input  alc_pkg::lvl_t lvl,
  input  logic          zc_l,
  input  logic          zc_r,
  input  logic [3:0]    step,
  output logic [GW-1:0] gain_l,
  output logic [GW-1:0] gain_r
);
  localparam int CW = TMO_LOG + 4;

  logic [GW-1:0] gl_q, gl_d, gr_q, gr_d, tgt_q, tgt_d, base;
  logic          pend_q, pend_d, dl_q, dl_d, dr_q, dr_d;
  logic [CW-1:0] cnt_q, cnt_d, tmo_last;
  logic          over, ovfs, tmo;

  function automatic logic [GW-1:0] cut(input logic [GW-1:0] b, input logic [3:0] s);
    cut = (b >= GW'(s)) ? (b - GW'(s)) : '0;
  endfunction

  assign over     = (lvl != alc_pkg::LV_NONE);
  assign ovfs     = (lvl >= alc_pkg::LV_FS);
  assign base     = pend_q ? tgt_q : gl_q;
  assign tmo_last = (CW'(1) << (TMO_LOG + int'(tmo_sel))) - 1'b1;
  assign tmo      = (cnt_q >= tmo_last);

  always_comb begin
    gl_d = gl_q; gr_d = gr_q; tgt_d = tgt_q;
    pend_d = pend_q; dl_d = dl_q; dr_d = dr_q; cnt_d = cnt_q;
    if (vld && en) begin
      if (zc_off) begin
        if (over) begin
          gl_d = cut(base, 4'd1); gr_d = cut(base, 4'd1); pend_d = 1'b0;
        end else if (pend_q) begin
          gl_d = tgt_q; gr_d = tgt_q; pend_d = 1'b0;
        end
      end else if (ovfs) begin
        gl_d = cut(base, step); gr_d = cut(base, step); pend_d = 1'b0;
      end else if (pend_q) begin
        if (zc_l || tmo) begin gl_d = tgt_q; dl_d = 1'b1; end
        if (zc_r || tmo) begin gr_d = tgt_q; dr_d = 1'b1; end
        if (tmo || ((dl_q || zc_l) && (dr_q || zc_r))) pend_d = 1'b0;
        else cnt_d = cnt_q + 1'b1;
      end else if (over) begin
        pend_d = 1'b1; tgt_d = cut(gl_q, step);
        cnt_d = '0; dl_d = 1'b0; dr_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gl_q <= GAIN_RST; gr_q <= GAIN_RST; tgt_q <= GAIN_RST;
      pend_q <= 1'b0; dl_q <= 1'b0; dr_q <= 1'b0; cnt_q <= '0;
    end else begin
      gl_q <= gl_d; gr_q <= gr_d; tgt_q <= tgt_d;
      pend_q <= pend_d; dl_q <= dl_d; dr_q <= dr_d; cnt_q <= cnt_d;
    end
  end

  assign gain_l = gl_q;
  assign gain_r = gr_q;

  AST_EQUAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> (gl_q == gr_q)); // R10
  AST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gl_q <= $past(gl_q)) && (gr_q <= $past(gr_q))); // R10
  AST_HOLD_NOSTB: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(gl_q) && $stable(gr_q)); // R11
  AST_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(gl_q) && $stable(gr_q) && $stable(pend_q)); // R1
  AST_ZCOFF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    vld && en && zc_off && !pend_q |=> (($past(gl_q) - gl_q) <= GW'(1))); // R6
  AST_FS_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    vld && en && !zc_off && ovfs |=> !pend_q && (gl_q == gr_q)); // R5
endmodule

// File: rtl/alc_limiter_top.sv
module alc_limiter_top #(
  parameter int            DW       = 18,
  parameter int            SW       = 16,
  parameter int            GW       = 8,
  parameter logic [GW-1:0] GAIN_RST = 8'd145,
  parameter int            TMO_LOG  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_l,
  input  logic signed [DW-1:0] smp_r,
  input  logic                 lim_en,
  input  logic [1:0]           thr_sel,
  input  logic [1:0]           stp_sel,
  input  logic                 zc_off,
  input  logic [1:0]           tmo_sel,
  output logic [GW-1:0]        gain_l,
  output logic [GW-1:0]        gain_r
);
  alc_pkg::lvl_t lvl_ch [2];
  alc_pkg::lvl_t lvl_max;
  logic [1:0]    zc_ch;
  logic [3:0]    step;
  logic signed [DW-1:0] smp_ch [2];

  assign smp_ch[0] = smp_l;
  assign smp_ch[1] = smp_r;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    alc_lvl_det #(.DW(DW), .SW(SW)) u_det (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .smp(smp_ch[c]),
      .thr_sel(thr_sel), .lvl(lvl_ch[c]), .zc(zc_ch[c])
    );
  end

  assign lvl_max = (lvl_ch[0] >= lvl_ch[1]) ? lvl_ch[0] : lvl_ch[1];

  alc_step_lut u_lut (
    .stp_sel(stp_sel), .zc_off(zc_off), .lvl(lvl_max), .step(step)
  );

  alc_gain_ctl #(.GW(GW), .GAIN_RST(GAIN_RST), .TMO_LOG(TMO_LOG)) u_ctl (
    .clk(clk), .rst_n(rst_n), .vld(smp_vld), .en(lim_en), .zc_off(zc_off),
    .tmo_sel(tmo_sel), .lvl(lvl_max), .zc_l(zc_ch[0]), .zc_r(zc_ch[1]),
    .step(step), .gain_l(gain_l), .gain_r(gain_r)
  );
endmodule

// File: tb/sim_alc_limiter_top.sv
module sim_alc_limiter_top;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0;
  logic signed [17:0] smp_l = '0, smp_r = '0;
  logic lim_en = 1'b1, zc_off = 1'b0;
  logic [1:0] thr_sel = '0, stp_sel = '0, tmo_sel = '0;
  logic [7:0] gain_l, gain_r;

  always #(CLK_PER/2) clk = ~clk;

  alc_limiter_top u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
    .lim_en(lim_en), .thr_sel(thr_sel), .stp_sel(stp_sel), .zc_off(zc_off),
    .tmo_sel(tmo_sel), .gain_l(gain_l), .gain_r(gain_r)
  );

  typedef struct { int gl; int gr; string tag; } exp_t;
  exp_t sbq[$];
  event pushed;
  int total = 0, bad = 0;

  // reference state built from the requirements
  int m_gl = 145, m_gr = 145, m_tgt = 145, m_cnt = 0;
  bit m_pend = 0, m_dl = 0, m_dr = 0, m_pnl = 0, m_pnr = 0;

  function automatic int region(int v);
    int thr[4] = '{24573, 20438, 16423, 12315};
    int m = (v < 0) ? -v : v;
    if (m >= 131072) return 4;
    if (m >= 65536)  return 3;
    if (m >= 32768)  return 2;
    if (m >= thr[thr_sel]) return 1;
    return 0;
  endfunction

  function automatic int step_of(int rg);
    int t[4][4] = '{'{1,1,1,1}, '{2,2,2,2}, '{2,4,4,8}, '{1,2,4,8}};
    return t[stp_sel][rg-1];
  endfunction

  function automatic int sat(int b, int s);
    return (b >= s) ? b - s : 0;
  endfunction

  task automatic model(int l, int r);
    bit zl = (l == 0) || ((l < 0) != m_pnl);
    bit zr = (r == 0) || ((r < 0) != m_pnr);
    int rl = region(l), rr = region(r);
    int rg = (rl > rr) ? rl : rr;
    int base = m_pend ? m_tgt : m_gl;
    bit tmo = (m_cnt >= (128 << tmo_sel) - 1);
    if (lim_en) begin
      if (zc_off) begin
        if (rg > 0) begin m_gl = sat(base, 1); m_gr = m_gl; m_pend = 0; end
        else if (m_pend) begin m_gl = m_tgt; m_gr = m_tgt; m_pend = 0; end
      end else if (rg >= 2) begin
        m_gl = sat(base, step_of(rg)); m_gr = m_gl; m_pend = 0;
      end else if (m_pend) begin
        if (zl || tmo) begin m_gl = m_tgt; m_dl = 1; end
        if (zr || tmo) begin m_gr = m_tgt; m_dr = 1; end
        if (tmo || (m_dl && m_dr)) m_pend = 0; else m_cnt++;
      end else if (rg == 1) begin
        m_pend = 1; m_tgt = sat(m_gl, step_of(1)); m_cnt = 0; m_dl = 0; m_dr = 0;
      end
    end
    m_pnl = (l < 0); m_pnr = (r < 0);
  endtask

  task automatic drive(int l, int r, string tag);
    exp_t e;
    @(negedge clk);
    smp_l = 18'(l); smp_r = 18'(r); smp_vld = 1'b1;
    model(l, r);
    @(negedge clk);
    smp_vld = 1'b0;
    e.gl = m_gl; e.gr = m_gr; e.tag = tag;
    sbq.push_back(e); ->pushed;
    @(negedge clk);
    e.tag = "R11";
    sbq.push_back(e); ->pushed;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @pushed;
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        total++;
        if (int'(gain_l) != e.gl || int'(gain_r) != e.gr) begin
          bad++;
          $display("FAIL %s: got l=%0d r=%0d expected l=%0d r=%0d",
                   e.tag, gain_l, gain_r, e.gl, e.gr);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PER * 200000);
    bad++; total++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int thr_tab[4] = '{24573, 20438, 16423, 12315};

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (gain_l !== 8'd145 || gain_r !== 8'd145) begin
      bad++;
      $display("FAIL R10 reset: got l=%0d r=%0d expected l=145 r=145", gain_l, gain_r);
    end
    // R7 R8 R9: steady tone over threshold, no crossings, timeout resolves
    stp_sel = 2'd3; tmo_sel = 2'd0;
    for (int i = 0; i < 131; i++) drive(25000, 25000, "R8");
    drive(-10, -10, "R7");
    drive(-10, -10, "R9");
    // R7: per-channel zero crossings
    stp_sel = 2'd1;
    drive(-25000, -25000, "R9");
    drive(100, -100, "R7");
    drive(100, 50, "R7");
    drive(100, 50, "R10");
    // R3 R4 R5: overload regions under each step select
    for (int s = 0; s < 4; s++) begin
      stp_sel = 2'(s);
      drive(40000, 10, "R5");
      drive(10, -70000, "R4");
      drive(-131072, 10, "R3");
    end
    // R5 with an outstanding pending change
    stp_sel = 2'd2;
    drive(-25000, -25000, "R7");
    drive(33000, -1000, "R5");
    // R1: disabled, nothing moves
    lim_en = 1'b0;
    drive(-131072, -131072, "R1");
    drive(25000, -25000, "R1");
    lim_en = 1'b1;
    // R2 R6: threshold sweep, zero-cross off
    zc_off = 1'b1; stp_sel = 2'd2;
    for (int t = 0; t < 4; t++) begin
      thr_sel = 2'(t);
      drive(thr_tab[t] - 1, -(thr_tab[t] - 1), "R2");
      drive(-thr_tab[t], 5, "R2");
      drive(5, thr_tab[t], "R6");
    end
    drive(-131072, 131071, "R6");
    // R8 with longer timeout
    zc_off = 1'b0; tmo_sel = 2'd1; stp_sel = 2'd0; thr_sel = 2'd0;
    for (int i = 0; i < 258; i++) drive(26000, 26000, "R8");
    // R10: saturation at zero
    zc_off = 1'b1;
    for (int i = 0; i < 150; i++) drive(30000, -30000, "R10");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule